// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block finishes the pair of interrupt-acknowledge bus cycles that a 16-bit processor runs when it accepts a maskable interrupt. A cycle responder raises `start` once it has classified a cycle as an acknowledge. From then on the sequencer owns the ready line and the data lanes until both cycles are complete.

Each processor bus state spans two system clocks, called phase 1 and phase 2. The `start` pulse comes during phase 2 of the first status state. The sequencer holds ready high through the first command state. That forces one inserted command state, during which it pulls ready low for two phases. It then waits while both status lines sit high. When a new status state begins, it checks that the second cycle is also an acknowledge. During the second cycle it places the 8-bit vector on the low byte lane and zero on the high byte lane.

A separate toggle input flips the interrupt request output. A test environment uses this to raise or drop the request between bus cycles.

Top module: `intack_seq`

## Requirements
- R1: After reset, `ready_n` is 1, both lane enables are 0, `data_out` is 0, and `intr`, `busy`, `done` and `err` are all 0.
- R2: When `start` is sampled high in the idle state, `ready_n` stays 1 for the next three clocks and then goes to 0 for exactly two clocks, the 4th and 5th clocks after the sampling edge. This shape repeats in the second cycle.
- R3: No lane enable is raised and `data_out` stays 0 during the first acknowledge cycle and during the idle gap that follows it.
- R4: After the first cycle, the sequencer waits for any number of clocks while `stat0_n` and `stat1_n` are both 1. `busy` stays 1 and ready stays high while it waits.
- R5: On the clock after either status line is first seen low, `stat0_n`, `stat1_n`, `code_inta` and `mem_io` must all be 0. If any of them is 1, `err` rises and stays high until reset. `busy` drops, ready stays high, nothing is driven and later `start` pulses are ignored.
- R6: During the five clocks of the second cycle, both lane enables are 1. `data_out[7:0]` carries the vector and `data_out[15:8]` is 0. Both enables drop on the same clock that `ready_n` returns to 1.
- R7: `done` is a single-clock pulse on the clock after the second cycle ends. `busy` is 1 from the clock after `start` until that clock.
- R8: Each clock with `irq_toggle` high inverts `intr` on the next clock.
- R9: The vector is captured on the status-check clock. Later changes on `vector` do not alter `data_out` during the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bus phase per period |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Responder detected an acknowledge (phase 2 of first status state) |
| stat0_n | input | 1 | Processor status line 0, active low |
| stat1_n | input | 1 | Processor status line 1, active low |
| code_inta | input | 1 | Code / interrupt-acknowledge status line |
| mem_io | input | 1 | Memory / IO status line |
| vector | input | 8 | Interrupt vector to return |
| irq_toggle | input | 1 | Toggle request for the interrupt request output |
| ready_n | output | 1 | Bus ready, active low |
| data_out | output | 16 | Data to drive on the bus lanes |
| lane_lo_oe | output | 1 | Drive enable for data bits 7:0 |
| lane_hi_oe | output | 1 | Drive enable for data bits 15:8 |
| intr | output | 1 | Interrupt request to the processor |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-clock pulse when the sequence completes |
| err | output | 1 | Sticky status-mismatch error |

## Verification
The bench varies the idle gap between the two cycles from zero clocks to several. A design that skipped the wait, or that checked status on the first low phase instead of the second, would fault or start the vector early. Second-cycle status words that are wrong in exactly one line are applied. A checker that tested only the two status lines would miss these, and would fail to raise `err` or fail to stop. The vector input is inverted right after capture, which would expose an unlatched vector path. Ready is checked at every phase, so that a missing inserted state or a one-phase ready pulse shows up as a miscompare.

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int VEC_W   = 8,
  parameter int PRE_PH  = 3,
  parameter int RDY_PH  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stat0_n,
  input  logic               stat1_n,
  input  logic               code_inta,
  input  logic               mem_io,
  input  logic [VEC_W-1:0]   vector,
  input  logic               irq_toggle,
  output logic               ready_n,
  output logic [2*VEC_W-1:0] data_out,
  output logic               lane_lo_oe,
  output logic               lane_hi_oe,
  output logic               intr,
  output logic               busy,
  output logic               done,
  output logic               err
);

  localparam int CYC_PH = PRE_PH + RDY_PH;
  localparam int CNT_W  = $clog2(CYC_PH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PH - 1);
  localparam logic [CNT_W-1:0] RDY0 = CNT_W'(PRE_PH);

  typedef enum logic [2:0] {S_IDLE, S_ACK1, S_GAP, S_CHK, S_ACK2, S_FAULT} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [VEC_W-1:0] vec_q;

  wire in_ack    = (st == S_ACK1) || (st == S_ACK2);
  wire stat_idle = stat0_n && stat1_n;
  wire stat_ok   = !stat0_n && !stat1_n && !code_inta && !mem_io;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      vec_q <= '0;
      done  <= 1'b0;
      intr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (irq_toggle) intr <= ~intr;
      case (st)
        S_IDLE: if (start) begin
          st  <= S_ACK1;
          cnt <= '0;
        end
        S_ACK1, S_ACK2: begin
          if (cnt == LAST) begin
            cnt <= '0;
            if (st == S_ACK1) st <= S_GAP;
            else begin
              st   <= S_IDLE;
              done <= 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: if (!stat_idle) st <= S_CHK;
        S_CHK: begin
          if (stat_ok) begin
            st    <= S_ACK2;
            vec_q <= vector;
          end else begin
            st <= S_FAULT;
          end
        end
        default: st <= S_FAULT;
      endcase
    end
  end

  assign ready_n    = !(in_ack && cnt >= RDY0);
  assign lane_lo_oe = (st == S_ACK2);
  assign lane_hi_oe = (st == S_ACK2);
  assign data_out   = lane_lo_oe ? {{VEC_W{1'b0}}, vec_q} : '0;
  assign busy       = (st != S_IDLE) && (st != S_FAULT);
  assign err        = (st == S_FAULT);

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_n) |=> !ready_n);
  // R2
  ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n && $past(!ready_n)) |=> ready_n);
  // R6
  hi_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_hi_oe |-> data_out[2*VEC_W-1:VEC_W] == '0);
  // R9
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_lo_oe && $past(lane_lo_oe)) |-> $stable(data_out));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && !busy);
  // R8
  intr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_toggle |=> intr != $past(intr));

endmodule

// File: tb/intack_seq_tb.sv
module intack_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        stat0_n = 1'b1, stat1_n = 1'b1, code_inta = 1'b1, mem_io = 1'b1;
  logic [7:0]  vector = 8'h00;
  logic        irq_toggle = 1'b0;
  logic        ready_n, lane_lo_oe, lane_hi_oe, intr, busy, done, err;
  logic [15:0] data_out;

  int applied = 0;
  int fails   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  intack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .stat0_n(stat0_n), .stat1_n(stat1_n), .code_inta(code_inta), .mem_io(mem_io),
    .vector(vector), .irq_toggle(irq_toggle),
    .ready_n(ready_n), .data_out(data_out),
    .lane_lo_oe(lane_lo_oe), .lane_hi_oe(lane_hi_oe),
    .intr(intr), .busy(busy), .done(done), .err(err)
  );

  // {vector, status word {s1,s0,cod,mio} at check, gap clocks}
  localparam logic [15:0] TBL [6] = '{
    {8'h21, 4'b0000, 4'd0},
    {8'hFF, 4'b0000, 4'd3},
    {8'h00, 4'b0000, 4'd7},
    {8'h5A, 4'b0001, 4'd1},
    {8'hA5, 4'b1000, 4'd2},
    {8'h3C, 4'b0010, 4'd0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_stat(input logic [3:0] s);
    {stat1_n, stat0_n, code_inta, mem_io} = s;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    irq_toggle = 1'b0;
    set_stat(4'b1111);
    tick(); tick();
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1
    chk("R1 ready_n", ready_n, 1);
    chk("R1 oe", {lane_hi_oe, lane_lo_oe}, 0);
    chk("R1 data", data_out, 0);
    chk("R1 flags", {intr, busy, done, err}, 0);

    for (int e = 0; e < 6; e++) begin
      logic [7:0] v;
      logic [3:0] sw;
      int gap;
      v = TBL[e][15:8];
      sw = TBL[e][7:4];
      gap = int'(TBL[e][3:0]);
      do_reset();
      vector = v;
      set_stat(4'b0000);
      start = 1'b1;
      tick();
      start = 1'b0;
      set_stat(4'b1111);
      for (int k = 0; k < 5; k++) begin
        chk("R2 ack1 ready_n", ready_n, (k >= 3) ? 0 : 1);
        chk("R3 ack1 no drive", {lane_hi_oe, lane_lo_oe, data_out}, 0);
        chk("R7 busy ack1", busy, 1);
        tick();
      end
      for (int g = 0; g < gap; g++) begin
        chk("R4 gap ready_n", ready_n, 1);
        chk("R3 gap no drive", {lane_hi_oe, lane_lo_oe}, 0);
        chk("R4 gap busy", busy, 1);
        tick();
      end
      set_stat(sw);
      tick();
      chk("R4 check phase ready_n", ready_n, 1);
      chk("R3 check phase no drive", {lane_hi_oe, lane_lo_oe}, 0);
      tick();
      set_stat(4'b1111);
      vector = ~v;
      if (sw != 4'b0000) begin
        chk("R5 err set", err, 1);
        chk("R5 busy low", busy, 0);
        chk("R5 ready high", ready_n, 1);
        chk("R5 no drive", {lane_hi_oe, lane_lo_oe}, 0);
        start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        chk("R5 start ignored", {err, busy, ready_n}, 3'b101);
      end else begin
        for (int k = 0; k < 5; k++) begin
          chk("R6 ack2 oe", {lane_hi_oe, lane_lo_oe}, 2'b11);
          chk("R9 ack2 data", data_out, {8'h00, v});
          chk("R2 ack2 ready_n", ready_n, (k >= 3) ? 0 : 1);
          chk("R7 no early done", done, 0);
          tick();
        end
        chk("R7 done pulse", done, 1);
        chk("R7 busy released", busy, 0);
        chk("R6 lanes released", {lane_hi_oe, lane_lo_oe, ready_n}, 3'b001);
        chk("R5 no err", err, 0);
        tick();
        chk("R7 done single", done, 0);
      end
    end

    // R8 toggle directed
    do_reset();
    irq_toggle = 1'b1;
    tick();
    irq_toggle = 1'b0;
    chk("R8 intr up", intr, 1);
    tick();
    chk("R8 intr held", intr, 1);
    irq_toggle = 1'b1;
    tick();
    irq_toggle = 1'b0;
    chk("R8 intr down", intr, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule